// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block is the 32-byte store that sits behind the block data port of an SMBus host controller. It is used only for SMBus block transactions, and only while buffer mode is selected. For a block write, software first loads the byte count into the count register. It then pushes payload bytes one after another through the block data port, and the bus engine drains them by index. For a block read, the engine stores the received count and the payload bytes. Software then pops the bytes in order through the same port.

Software and the buffer share one index, and that index only moves forward. Any read of the host control register sends it back to entry 0. A count outside 1..32 is flagged as a protocol error. The engine uses that flag to reject a received length, and software uses it to reject a programmed one. The bus engine itself is outside this block. It reaches the storage through its own indexed port.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the shared index is 0, every entry holds 0x00, the count register holds 0x00 and the count error flag is high.
- R2: Buffer mode (`bufMode`) is high only when `auxCtl` bit 1 is set and `hostCnt` bits 4:2 equal 3'b101 (protocol code 0x14). The I2C block code 0x18 (bits 4:2 = 3'b110) never enables it.
- R3: In buffer mode, a `blkWrEn` strobe stores `blkWrData` at the shared index, and the index goes up by one on the next cycle.
- R4: In buffer mode, `blkRdData` shows the entry at the shared index in the same cycle. A `blkRdEn` strobe moves the index up by one.
- R5: A `ctlRdEn` strobe returns the index to 0 at the next cycle. A software access in the same cycle is ignored.
- R6: The index stops at 32. At that point writes are dropped, the index does not move, and `blkRdData` reads 0x00.
- R7: With buffer mode off, software strobes store nothing and leave the index unchanged, and `blkRdData` reads 0x00.
- R8: `cntWrEn` loads `cntWrData` into the count register, and `engCntWr` loads `engCntData` into it. When both occur in one cycle, the engine value wins.
- R9: `cntErr` is high whenever the count register holds 0 or a value above 32.
- R10: `engRdData` shows the entry at `engIdx` in the same cycle, and `engWrEn` stores `engWrData` there. An engine write beats a software write to the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| auxCtl | input | 8 | Auxiliary control register value; bit 1 selects buffer mode |
| hostCnt | input | 8 | Host control register value; bits 4:2 give the protocol |
| ctlRdEn | input | 1 | Strobe for any read of the host control register |
| blkWrEn | input | 1 | Software write strobe on the block data port |
| blkWrData | input | 8 | Software write byte |
| blkRdEn | input | 1 | Software read strobe on the block data port |
| blkRdData | output | 8 | Byte at the shared index |
| cntWrEn | input | 1 | Software write strobe for the count register |
| cntWrData | input | 8 | Count written by software |
| cntData | output | 8 | Current count register value |
| cntErr | output | 1 | Count outside 1..32 |
| bufMode | output | 1 | Buffer mode in effect |
| engIdx | input | 5 | Engine entry index |
| engWrEn | input | 1 | Engine store strobe |
| engWrData | input | 8 | Engine store byte |
| engRdData | output | 8 | Entry at engIdx |
| engCntWr | input | 1 | Engine write of the received count |
| engCntData | input | 8 | Received count |

## Verification
The hardest state to reach is a saturated index that meets a same-cycle conflict. One case is a control register read or an engine write that lands in the same cycle as a software access. The other is a software write made while the protocol field holds the I2C block code. Directed sequences fill all 32 entries, push past the end, and line up these collisions cycle by cycle. A seeded random phase then toggles the mode inputs, the index resets and both ports together against a reference model of the buffer.

// File: rtl/smbbuf_pkg.sv
package smbbuf_pkg;
  localparam int BUF_DEPTH = 32;
  localparam int IDX_W = $clog2(BUF_DEPTH + 1);
  localparam int ENG_W = $clog2(BUF_DEPTH);
  localparam logic [2:0] PROTO_SMB_BLOCK = 3'b101;

  typedef struct packed {
    logic             store;
    logic             inRange;
    logic [IDX_W-1:0] idx;
  } bufStrobe_t;
endpackage

// File: rtl/smbbuf_ctrl.sv
module smbbuf_ctrl
  import smbbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] auxCtl,
  input  logic [7:0] hostCnt,
  input  logic       ctlRdEn,
  input  logic       swWrEn,
  input  logic       swRdEn,
  output logic       bufMode,
  output bufStrobe_t strb
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BUF_DEPTH);

  logic [IDX_W-1:0] idx;
  logic inRange;
  logic step;

  // protocol field bits 4:2 select SMBus block; aux bit 1 enables the buffer
  assign bufMode = auxCtl[1] && (hostCnt[4:2] == PROTO_SMB_BLOCK);
  assign inRange = bufMode && (idx < IDX_END);
  assign step    = inRange && (swWrEn || swRdEn) && !ctlRdEn;

  always_ff @(posedge clk) begin
    if (!rstN)        idx <= '0;
    else if (ctlRdEn) idx <= '0;
    else if (step)    idx <= idx + 1'b1;
  end

  always_comb begin
    strb.store   = inRange && swWrEn && !ctlRdEn;
    strb.inRange = inRange;
    strb.idx     = idx;
  end
endmodule

// File: rtl/smbbuf_dpath.sv
module smbbuf_dpath
  import smbbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic [DATA_W-1:0] swWrData,
  output logic [DATA_W-1:0] swRdData,
  input  logic              cntWrEn,
  input  logic [DATA_W-1:0] cntWrData,
  output logic [DATA_W-1:0] cntData,
  output logic              cntErr,
  input  logic [ENG_W-1:0]  engIdx,
  input  logic              engWrEn,
  input  logic [DATA_W-1:0] engWrData,
  output logic [DATA_W-1:0] engRdData,
  input  logic              engCntWr,
  input  logic [DATA_W-1:0] engCntData
);
  localparam logic [DATA_W-1:0] CNT_MAX = DATA_W'(BUF_DEPTH);

  logic [DATA_W-1:0] memQ [BUF_DEPTH];
  logic [DATA_W-1:0] cntQ;

  for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= '0;
      else if (engWrEn && engIdx == ENG_W'(e))
        q <= engWrData;
      else if (strb.store && strb.idx == IDX_W'(e))
        q <= swWrData;
    end
    assign memQ[e] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         cntQ <= '0;
    else if (engCntWr) cntQ <= engCntData;
    else if (cntWrEn)  cntQ <= cntWrData;
  end

  assign swRdData  = strb.inRange ? memQ[strb.idx[ENG_W-1:0]] : '0;
  assign engRdData = memQ[engIdx];
  assign cntData   = cntQ;
  assign cntErr    = (cntQ == '0) || (cntQ > CNT_MAX);
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
  import smbbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] auxCtl,
  input  logic [7:0] hostCnt,
  input  logic       ctlRdEn,
  input  logic       blkWrEn,
  input  logic [7:0] blkWrData,
  input  logic       blkRdEn,
  output logic [7:0] blkRdData,
  input  logic       cntWrEn,
  input  logic [7:0] cntWrData,
  output logic [7:0] cntData,
  output logic       cntErr,
  output logic       bufMode,
  input  logic [4:0] engIdx,
  input  logic       engWrEn,
  input  logic [7:0] engWrData,
  output logic [7:0] engRdData,
  input  logic       engCntWr,
  input  logic [7:0] engCntData
);
  bufStrobe_t strb;

  smbbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .auxCtl(auxCtl), .hostCnt(hostCnt),
    .ctlRdEn(ctlRdEn), .swWrEn(blkWrEn), .swRdEn(blkRdEn),
    .bufMode(bufMode), .strb(strb)
  );

  smbbuf_dpath #(.DATA_W(8)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .swWrData(blkWrData), .swRdData(blkRdData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntData(cntData), .cntErr(cntErr),
    .engIdx(engIdx), .engWrEn(engWrEn), .engWrData(engWrData),
    .engRdData(engRdData), .engCntWr(engCntWr), .engCntData(engCntData)
  );
endmodule

// File: rtl/smbbuf_chk.sv
module smbbuf_chk
  import smbbuf_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ctlRdEn,
  input logic       blkWrEn,
  input logic       blkRdEn,
  input logic [7:0] blkRdData,
  input logic       bufMode,
  input logic       engCntWr,
  input logic [7:0] engCntData,
  input logic [7:0] cntData,
  input bufStrobe_t strb
);
  // R5
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdEn |=> strb.idx == '0);

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idx <= IDX_W'(BUF_DEPTH));

  // R6
  idx_hold_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.idx == IDX_W'(BUF_DEPTH) && !ctlRdEn) |=> $stable(strb.idx));

  // R7
  idx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bufMode && !ctlRdEn) |=> $stable(strb.idx));

  // R7
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bufMode |-> blkRdData == 8'h00);

  // R8
  eng_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    engCntWr |=> cntData == $past(engCntData));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && !ctlRdEn && (blkWrEn || blkRdEn) && strb.idx < IDX_W'(BUF_DEPTH))
      |=> strb.idx == $past(strb.idx) + 1'b1);
endmodule

bind smbus_blkbuf smbbuf_chk u_chk (
  .clk(clk), .rstN(rstN), .ctlRdEn(ctlRdEn), .blkWrEn(blkWrEn),
  .blkRdEn(blkRdEn), .blkRdData(blkRdData), .bufMode(bufMode),
  .engCntWr(engCntWr), .engCntData(engCntData), .cntData(cntData),
  .strb(strb)
);

// File: tb/tb_smbus_blkbuf.sv
module tb_smbus_blkbuf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rstN = 0;
  logic [7:0] auxCtl = 0, hostCnt = 0;
  logic ctlRdEn = 0, blkWrEn = 0, blkRdEn = 0, cntWrEn = 0;
  logic [7:0] blkWrData = 0, cntWrData = 0, engWrData = 0, engCntData = 0;
  logic [4:0] engIdx = 0;
  logic engWrEn = 0, engCntWr = 0;
  logic [7:0] blkRdData, cntData, engRdData;
  logic cntErr, bufMode;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] refMem [DEPTH];
  int refIdx;
  logic [7:0] refCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_blkbuf dut (
    .clk(clk), .rstN(rstN), .auxCtl(auxCtl), .hostCnt(hostCnt),
    .ctlRdEn(ctlRdEn), .blkWrEn(blkWrEn), .blkWrData(blkWrData),
    .blkRdEn(blkRdEn), .blkRdData(blkRdData), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .cntData(cntData), .cntErr(cntErr),
    .bufMode(bufMode), .engIdx(engIdx), .engWrEn(engWrEn),
    .engWrData(engWrData), .engRdData(engRdData), .engCntWr(engCntWr),
    .engCntData(engCntData)
  );

  function automatic bit expMode(input logic [7:0] a, input logic [7:0] h);
    return a[1] && (h[4:2] == 3'b101);
  endfunction

  function automatic logic [7:0] expRd();
    if (expMode(auxCtl, hostCnt) && refIdx < DEPTH) return refMem[refIdx];
    return 8'h00;
  endfunction

  function automatic bit expErr(input logic [7:0] c);
    return (c == 0) || (c > DEPTH);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string rdTag);
    check(rdTag, blkRdData, expRd());
    check("R2 bufMode", {7'd0, bufMode}, {7'd0, expMode(auxCtl, hostCnt)});
    check("R8 cntData", cntData, refCnt);
    check("R9 cntErr", {7'd0, cntErr}, {7'd0, expErr(refCnt)});
    check("R10 engRdData", engRdData, refMem[engIdx]);
  endtask

  // one clock: inputs driven at negedge, outputs checked before the edge, model stepped at the edge
  task automatic cyc(input string rdTag, input bit wr, input bit rd, input bit ctl,
                     input logic [7:0] wd, input bit cw, input logic [7:0] cwd,
                     input bit ew, input logic [4:0] ei, input logic [7:0] ed,
                     input bit ecw, input logic [7:0] ecd);
    bit m;
    blkWrEn = wr; blkRdEn = rd; ctlRdEn = ctl; blkWrData = wd;
    cntWrEn = cw; cntWrData = cwd; engWrEn = ew; engIdx = ei; engWrData = ed;
    engCntWr = ecw; engCntData = ecd;
    #1;
    checkAll(rdTag);
    m = expMode(auxCtl, hostCnt);
    @(posedge clk);
    if (ctl) refIdx = 0;
    else if (m && refIdx < DEPTH && (wr || rd)) begin
      if (wr) refMem[refIdx] = wd;
      refIdx++;
    end
    if (ew) refMem[ei] = ed;
    if (ecw) refCnt = ecd;
    else if (cw) refCnt = cwd;
    @(negedge clk);
    blkWrEn = 0; blkRdEn = 0; ctlRdEn = 0; cntWrEn = 0; engWrEn = 0; engCntWr = 0;
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 8'h00, 0, 8'h00, 0, engIdx, 8'h00, 0, 8'h00);
  endtask
  task automatic swWr(input string tag, input logic [7:0] d);
    cyc(tag, 1, 0, 0, d, 0, 8'h00, 0, engIdx, 8'h00, 0, 8'h00);
  endtask
  task automatic swRd(input string tag);
    cyc(tag, 0, 1, 0, 8'h00, 0, 8'h00, 0, engIdx, 8'h00, 0, 8'h00);
  endtask
  task automatic ctlRd(input string tag);
    cyc(tag, 0, 0, 1, 8'h00, 0, 8'h00, 0, engIdx, 8'h00, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    refIdx = 0; refCnt = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    checkAll("R1 reset read");
    check("R1 reset cntErr", {7'd0, cntErr}, 8'h01);
    for (int i = 0; i < DEPTH; i++) begin
      engIdx = 5'(i); #1; check("R1 reset entry", engRdData, 8'h00);
    end

    // R2 mode decode, including I2C block code 0x18
    auxCtl = 8'h02; hostCnt = 8'h18; #1; check("R2 i2c block", {7'd0, bufMode}, 8'h00);
    auxCtl = 8'h00; hostCnt = 8'h14; #1; check("R2 aux off", {7'd0, bufMode}, 8'h00);
    auxCtl = 8'h02; hostCnt = 8'h54; #1; check("R2 on", {7'd0, bufMode}, 8'h01);

    // R3/R4 block write then ordered read back
    cyc("R8", 0, 0, 0, 8'h00, 1, 8'h03, 0, 5'd0, 8'h00, 0, 8'h00);
    swWr("R3", 8'hA1); swWr("R3", 8'hB2); swWr("R3", 8'hC3);
    ctlRd("R5");
    swRd("R4 first"); swRd("R4 second"); swRd("R4 third");

    // R7 writes while the I2C block code is selected are ignored
    ctlRd("R5");
    hostCnt = 8'h18;
    swWr("R7 ignored", 8'h55); swRd("R7 ignored");
    hostCnt = 8'h14;
    idle("R7 no advance"); check("R7 old byte kept", blkRdData, 8'hA1);

    // R5 control read beats a same-cycle software write
    swWr("R3", 8'h11);
    cyc("R5 collide", 1, 0, 1, 8'h99, 0, 8'h00, 0, 5'd0, 8'h00, 0, 8'h00);
    idle("R5 after"); check("R5 entry0", blkRdData, 8'h11);
    engIdx = 5'd1; #1; check("R5 entry1 kept", engRdData, 8'hB2);

    // R6 fill all 32 then push past the end
    for (int i = 0; i < DEPTH; i++) swWr("R6 fill", 8'(8'h40 + i));
    swWr("R6 dropped", 8'hEE); swRd("R6 zero");
    check("R6 read at end", blkRdData, 8'h00);
    engIdx = 5'd31; #1; check("R6 last entry", engRdData, 8'h5F);
    ctlRd("R5");
    for (int i = 0; i < DEPTH; i++) swRd("R6 readback");

    // R8/R9 count register and validation bounds
    cyc("R8", 0, 0, 0, 8'h00, 1, 8'h21, 0, 5'd0, 8'h00, 0, 8'h00);
    check("R9 33 bad", {7'd0, cntErr}, 8'h01);
    cyc("R8", 0, 0, 0, 8'h00, 0, 8'h00, 0, 5'd0, 8'h00, 1, 8'h20);
    check("R9 32 ok", {7'd0, cntErr}, 8'h00);
    cyc("R8", 0, 0, 0, 8'h00, 1, 8'h05, 0, 5'd0, 8'h00, 1, 8'h01);
    check("R8 engine wins", cntData, 8'h01);
    check("R9 1 ok", {7'd0, cntErr}, 8'h00);

    // R10 engine write beats software write to the same entry
    ctlRd("R5");
    cyc("R10", 1, 0, 0, 8'h77, 0, 8'h00, 1, 5'd0, 8'h88, 0, 8'h00);
    engIdx = 5'd0; #1; check("R10 collide", engRdData, 8'h88);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) auxCtl = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'h02;
      if ($urandom_range(0, 15) == 0) hostCnt = ($urandom_range(0, 3) == 0) ? 8'h18 : 8'h14;
      cyc("R4 random",
          op < 4, op == 4 || op == 5, op == 6,
          8'($urandom), op == 7, 8'($urandom_range(0, 40)),
          $urandom_range(0, 3) == 0, 5'($urandom), 8'($urandom),
          $urandom_range(0, 7) == 0, 8'($urandom_range(0, 40)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule